// File: doc/BRIEF.md
# Periodic Transmit Request Queue

This block queues transfer requests for periodic host traffic (isochronous and interrupt) and keeps count of the free space in the companion periodic transmit data FIFO. Host logic writes one 8-bit request per cycle into a short first-in first-out queue. The transaction engine reads the entry at the head and pops it when the request has been handled. IN and OUT requests share the same queue.

A second counter follows the data FIFO. It receives one strobe for each 32-bit word written into the FIFO and one strobe for each word drained from it, and it reports how many words are still free. The head entry, the free queue slots and the free FIFO words are packed together into one read-only 32-bit status word. The data FIFO storage itself is outside this block.

Top module: `ptx_req_queue`

## Requirements
- R1: After reset, with default parameters, `status_word` reads 0x0008_0100, `head_valid` is 0, `queue_overflow` is 0 and `space_error` is 0.
- R2: A request entry is 8 bits. Bit 0 is the last-request flag, bits 2:1 are the type (00 IN/OUT token, 01 zero-length packet, 10 reserved, 11 channel-disable command), bits 6:3 are the channel number, and bit 7 selects the frame (0 even, 1 odd). Entries leave `head_entry` unchanged in bit value and in the order they were written.
- R3: Free request slots equal the queue depth (8 by default) minus the occupancy. The count changes at the same clock edge that accepts the push or the pop, and reads 0 when the queue is full.
- R4: A push with no pop while the queue is full is dropped. `queue_overflow` is then high for exactly the one cycle that follows that edge.
- R5: A pop while the queue is empty is ignored and leaves the free slot count unchanged.
- R6: While the queue is empty, `head_entry` reads 0x00 and `head_valid` is 0.
- R7: `status_word` holds the head entry in bits 31:24, the free request slots in bits 23:16 and the free FIFO words in bits 15:0.
- R8: Each `word_push` lowers the free word count by one and each `word_drain` raises it by one. When both arrive in the same cycle the count does not change. The count resets to 256 words.
- R9: The free word count stops at 0. A `word_push` with no drain while the count is 0 sets `space_error`, which stays set until reset.
- R10: The free word count stops at the FIFO depth (512 by default). A drain with no push at that value leaves it unchanged.
- R11: A push and a pop in the same cycle on a full queue are both accepted. The slot count stays at 0, the head moves to the next entry, and no overflow is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_push | input | 1 | Write `req_entry` into the queue |
| req_entry | input | 8 | Request entry to write |
| req_pop | input | 1 | Remove the head entry |
| head_entry | output | 8 | Entry at the head, 0x00 when the queue is empty |
| head_valid | output | 1 | The queue holds at least one entry |
| queue_overflow | output | 1 | One-cycle pulse after a dropped push |
| word_push | input | 1 | One word was written into the data FIFO |
| word_drain | input | 1 | One word was drained from the data FIFO |
| space_error | output | 1 | Sticky flag: a word was written while the FIFO was full |
| status_word | output | 32 | Packed status: head, free slots, free words |

## Verification
A read or write pointer that drifts shows up as a head entry that does not match the order in which entries were written. This becomes visible at the first pop after the fault, and at the latest once the pointers wrap after eight entries. An occupancy count that is wrong shows up in bits 23:16 of the status word at the next edge, and also as a missing or extra overflow pulse when the queue is filled. Saturation faults in the word counter only appear at the extremes, so the counter is driven all the way to 512 and down to 0, with one more strobe in each direction at the limit.

// File: rtl/ptxq_pkg.sv
package ptxq_pkg;

   localparam int ENTRY_W  = 8;
   localparam int STATUS_W = 32;

   typedef enum logic [1:0] {
      REQ_TOKEN   = 2'b00,
      REQ_ZLP     = 2'b01,
      REQ_RSVD    = 2'b10,
      REQ_CH_STOP = 2'b11
   } req_kind_e;

   typedef struct packed {
      logic      odd_frame;
      logic [3:0] chan;
      req_kind_e kind;
      logic      last;
   } req_entry_t;

   typedef struct packed {
      req_entry_t  head;
      logic [7:0]  free_slots;
      logic [15:0] free_words;
   } ptx_status_t;

endpackage

// File: rtl/ptxq_req_fifo.sv
module ptxq_req_fifo #(
   parameter int DEPTH = 8,
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] head,
   output logic             head_valid,
   output logic [$clog2(DEPTH+1)-1:0] used,
   output logic             overflow
);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit POW2  = (DEPTH > 1) && ((DEPTH & (DEPTH - 1)) == 0);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   if (DEPTH < 1) begin : g_bad_depth
      $error("ptxq_req_fifo: DEPTH must be at least 1");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("ptxq_req_fifo: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic             is_full, is_empty, do_push, do_pop;

   assign is_full  = (used == FULL_CNT);
   assign is_empty = (used == '0);
   assign do_pop   = pop && !is_empty;
   assign do_push  = push && (!is_full || do_pop);

   // pointer advance: free-running wrap for power-of-two depths
   if (POW2) begin : g_wrap_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) begin
         mem[wr_ptr] <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr   <= '0;
         rd_ptr   <= '0;
         used     <= '0;
         overflow <= 1'b0;
      end else begin
         if (do_push) wr_ptr <= wr_nxt;
         if (do_pop)  rd_ptr <= rd_nxt;
         case ({do_push, do_pop})
            2'b10:   used <= used + 1'b1;
            2'b01:   used <= used - 1'b1;
            default: used <= used;
         endcase
         overflow <= push && !do_push;
      end
   end

   assign head_valid = !is_empty;
   assign head       = is_empty ? '0 : mem[rd_ptr];

   // R3: occupancy never exceeds the depth
   p_used_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      used <= FULL_CNT);

   // R4: dropped push leaves occupancy and raises the pulse
   p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && is_full) |=> (overflow && used == FULL_CNT));

   // R5: pop on empty keeps the queue empty
   p_pop_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && is_empty) |=> (used == '0));

   // R6: draining the last entry clears the head
   p_last_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (used == CNT_W'(1) && pop && !push) |=> (!head_valid && head == '0));

   // R11: simultaneous push and pop on full keeps it full without overflow
   p_full_swap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && is_full) |=> (!overflow && used == FULL_CNT));

endmodule

// File: rtl/ptxq_word_space.sv
module ptxq_word_space #(
   parameter int MAX_WORDS   = 512,
   parameter int RESET_WORDS = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_word,
   input  logic rd_word,
   output logic [$clog2(MAX_WORDS+1)-1:0] free_words,
   output logic space_err
);
   localparam int CNT_W = $clog2(MAX_WORDS + 1);
   localparam logic [CNT_W-1:0] TOP  = CNT_W'(MAX_WORDS);
   localparam logic [CNT_W-1:0] INIT = CNT_W'(RESET_WORDS);

   if (MAX_WORDS < 1 || MAX_WORDS > 512) begin : g_bad_max
      $error("ptxq_word_space: MAX_WORDS must be within 1..512");
   end
   if (RESET_WORDS < 0 || RESET_WORDS > MAX_WORDS) begin : g_bad_init
      $error("ptxq_word_space: RESET_WORDS must be within 0..MAX_WORDS");
   end

   logic at_zero, at_top, take, give;

   assign at_zero = (free_words == '0);
   assign at_top  = (free_words == TOP);
   assign take    = wr_word && !rd_word;
   assign give    = rd_word && !wr_word;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         free_words <= INIT;
         space_err  <= 1'b0;
      end else begin
         if (take && !at_zero)     free_words <= free_words - 1'b1;
         else if (give && !at_top) free_words <= free_words + 1'b1;
         if (take && at_zero)      space_err  <= 1'b1;
      end
   end

   // R9: saturation at zero with error
   p_sat_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (take && at_zero) |=> (free_words == '0 && space_err));

   // R9: error flag is sticky
   p_sticky_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
      space_err |=> space_err);

   // R10: saturation at the depth
   p_sat_top_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (give && at_top) |=> (free_words == TOP));

   // R8: paired strobes leave the count alone
   p_pair_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_word && rd_word) |=> $stable(free_words));

   // R8: count stays inside its range
   p_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      free_words <= TOP);

endmodule

// File: rtl/ptxq_status_pack.sv
module ptxq_status_pack
   import ptxq_pkg::*;
#(
   parameter int SLOT_W = 4,
   parameter int WORD_W = 10
) (
   input  logic [ENTRY_W-1:0]  head,
   input  logic [SLOT_W-1:0]   free_slots,
   input  logic [WORD_W-1:0]   free_words,
   output logic [STATUS_W-1:0] status
);
   if (SLOT_W > 8) begin : g_bad_slot
      $error("ptxq_status_pack: slot count does not fit its 8-bit field");
   end
   if (WORD_W > 16) begin : g_bad_word
      $error("ptxq_status_pack: word count does not fit its 16-bit field");
   end

   ptx_status_t st;

   always_comb begin
      st            = '0;
      st.head       = req_entry_t'(head);
      st.free_slots = 8'(free_slots);
      st.free_words = 16'(free_words);
   end

   assign status = st;

endmodule

// File: rtl/ptx_req_queue.sv
module ptx_req_queue
   import ptxq_pkg::*;
#(
   parameter int QUEUE_DEPTH = 8,
   parameter int FIFO_WORDS  = 512,
   parameter int FREE_RESET  = 256
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_push,
   input  logic [7:0]  req_entry,
   input  logic        req_pop,
   output logic [7:0]  head_entry,
   output logic        head_valid,
   output logic        queue_overflow,
   input  logic        word_push,
   input  logic        word_drain,
   output logic        space_error,
   output logic [31:0] status_word
);
   localparam int SLOT_W = $clog2(QUEUE_DEPTH + 1);
   localparam int WORD_W = $clog2(FIFO_WORDS + 1);

   if (QUEUE_DEPTH < 1 || QUEUE_DEPTH > 255) begin : g_bad_q
      $error("ptx_req_queue: QUEUE_DEPTH must be within 1..255");
   end

   logic [SLOT_W-1:0] used, free_slots;
   logic [WORD_W-1:0] free_words;

   ptxq_req_fifo #(.DEPTH(QUEUE_DEPTH), .WIDTH(ENTRY_W)) u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (req_push),
      .din        (req_entry),
      .pop        (req_pop),
      .head       (head_entry),
      .head_valid (head_valid),
      .used       (used),
      .overflow   (queue_overflow)
   );

   assign free_slots = SLOT_W'(QUEUE_DEPTH) - used;

   ptxq_word_space #(.MAX_WORDS(FIFO_WORDS), .RESET_WORDS(FREE_RESET)) u_space (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_word    (word_push),
      .rd_word    (word_drain),
      .free_words (free_words),
      .space_err  (space_error)
   );

   ptxq_status_pack #(.SLOT_W(SLOT_W), .WORD_W(WORD_W)) u_pack (
      .head       (head_entry),
      .free_slots (free_slots),
      .free_words (free_words),
      .status     (status_word)
   );

   // R7: status fields agree with the separate outputs
   p_pack_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
      status_word[31:24] == head_entry);

   // R3: a queue that reports no free slot still reports a head
   p_full_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (status_word[23:16] == 8'd0) |-> head_valid);

endmodule

// File: tb/ptx_req_queue_test.sv
module ptx_req_queue_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_push = 1'b0, req_pop = 1'b0;
   logic [7:0]  req_entry = '0;
   logic        word_push = 1'b0, word_drain = 1'b0;
   logic [7:0]  head_entry;
   logic        head_valid, queue_overflow, space_error;
   logic [31:0] status_word;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   ptx_req_queue uut (
      .clk(clk), .rst_n(rst_n),
      .req_push(req_push), .req_entry(req_entry), .req_pop(req_pop),
      .head_entry(head_entry), .head_valid(head_valid),
      .queue_overflow(queue_overflow),
      .word_push(word_push), .word_drain(word_drain),
      .space_error(space_error), .status_word(status_word)
   );

   // {push, pop, entry, expected head, expected free slots}
   localparam logic [25:0] VEC [8] = '{
      {1'b1, 1'b0, 8'h8B, 8'h8B, 8'd7},
      {1'b1, 1'b0, 8'h12, 8'h8B, 8'd6},
      {1'b0, 1'b1, 8'h00, 8'h12, 8'd7},
      {1'b1, 1'b1, 8'h36, 8'h36, 8'd7},
      {1'b0, 1'b1, 8'h00, 8'h00, 8'd8},
      {1'b0, 1'b1, 8'h00, 8'h00, 8'd8},
      {1'b1, 1'b1, 8'hFE, 8'hFE, 8'd7},
      {1'b0, 1'b1, 8'h00, 8'h00, 8'd8}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic cyc(input logic p, input logic q, input logic [7:0] d,
                      input logic wp, input logic wd);
      req_push = p; req_pop = q; req_entry = d; word_push = wp; word_drain = wd;
      @(posedge clk); #2;
      req_push = 1'b0; req_pop = 1'b0; word_push = 1'b0; word_drain = 1'b0;
   endtask

   function automatic logic [7:0] ent(input int i);
      return 8'(8'h81 + i * 8'h13);
   endfunction

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      // R1 reset state
      chk("R1 status", status_word, 32'h0008_0100);
      chk("R1 flags", {29'd0, head_valid, queue_overflow, space_error}, 32'd0);

      // vector table: R2 R3 R5 R6 R7
      foreach (VEC[i]) begin
         cyc(VEC[i][25], VEC[i][24], VEC[i][23:16], 1'b0, 1'b0);
         chk("R2 head", {24'd0, head_entry}, {24'd0, VEC[i][15:8]});
         chk("R3 slots R7", {24'd0, status_word[23:16]}, {24'd0, VEC[i][7:0]});
         chk("R7 packed", status_word, {VEC[i][15:8], VEC[i][7:0], 16'h0100});
         if (VEC[i][15:8] == 8'h00)
            chk("R6 empty", {31'd0, head_valid}, 32'd0);
      end

      // fill: R3 full reads 0
      for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, ent(i), 1'b0, 1'b0);
      chk("R3 full", {24'd0, status_word[23:16]}, 32'd0);
      chk("R4 no pulse before", {31'd0, queue_overflow}, 32'd0);
      // R4 overflow
      cyc(1'b1, 1'b0, 8'hAA, 1'b0, 1'b0);
      chk("R4 pulse", {31'd0, queue_overflow}, 32'd1);
      chk("R4 head kept", {24'd0, head_entry}, {24'd0, ent(0)});
      chk("R4 slots", {24'd0, status_word[23:16]}, 32'd0);
      cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
      chk("R4 one cycle", {31'd0, queue_overflow}, 32'd0);
      // R11 swap on full
      cyc(1'b1, 1'b1, ent(8), 1'b0, 1'b0);
      chk("R11 no ovf", {31'd0, queue_overflow}, 32'd0);
      chk("R11 slots", {24'd0, status_word[23:16]}, 32'd0);
      chk("R11 head", {24'd0, head_entry}, {24'd0, ent(1)});
      // R2 order through wrap; dropped 0xAA must never appear
      for (int i = 1; i <= 8; i++) begin
         chk("R2 order", {24'd0, head_entry}, {24'd0, ent(i)});
         cyc(1'b0, 1'b1, 8'h00, 1'b0, 1'b0);
      end
      chk("R6 drained", {23'd0, head_valid, head_entry}, 32'd0);
      chk("R5 slots", {24'd0, status_word[23:16]}, 32'd8);

      // R8 word counter
      for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
      chk("R8 push", {16'd0, status_word[15:0]}, 32'd253);
      cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
      chk("R8 drain", {16'd0, status_word[15:0]}, 32'd254);
      cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
      chk("R8 both", {16'd0, status_word[15:0]}, 32'd254);
      // R10 upper saturation
      for (int i = 0; i < 258; i++) cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
      chk("R10 top", {16'd0, status_word[15:0]}, 32'd512);
      cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
      chk("R10 hold", {16'd0, status_word[15:0]}, 32'd512);
      // R9 lower saturation
      for (int i = 0; i < 512; i++) cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
      chk("R9 zero", {16'd0, status_word[15:0]}, 32'd0);
      chk("R9 no err yet", {31'd0, space_error}, 32'd0);
      cyc(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
      chk("R9 hold", {16'd0, status_word[15:0]}, 32'd0);
      chk("R9 err", {31'd0, space_error}, 32'd1);
      cyc(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
      chk("R9 sticky", {31'd0, space_error}, 32'd1);
      chk("R9 recover", {16'd0, status_word[15:0]}, 32'd1);

      // R1 reset again
      rst_n = 1'b0;
      @(posedge clk); #2 rst_n = 1'b1;
      chk("R1 re-reset", {space_error, status_word[30:0]}, 32'h0008_0100);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule